// File: doc/BRIEF.md
# Union-Find Segment Merging Engine

This block groups graph vertices (image pixels) into segments. It walks a sorted edge list from an external edge store. Each entry holds a source vertex, a neighbour vertex and a weight. For every vertex the block keeps four attributes in its own register arrays: a parent label, a rank, an adaptive threshold and a component size. For each edge it locates the root of both endpoints. It then decides whether the two components should be fused, and if so it joins them by rank.

A pass is launched with `start_i` and can run in one of two modes. A threshold pass first resets every vertex to a singleton carrying a global threshold. It then fuses two components only when the edge weight is within the threshold of both. The fused root's threshold becomes the weight plus k divided by the new size. A min-size pass keeps the existing forest and fuses two distinct components whenever either one is smaller than a user limit. The usual sequence is a threshold pass followed by a min-size pass. A combinational query port returns the attributes of any vertex once the block is idle.

Top module: `seg_merge_engine`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0. Every vertex v has label v, rank 0, size 1 and threshold 0.
- R2: A start with `mode_i`=0 (threshold mode) sets every vertex to label v, rank 0, size 1 and threshold `thr_init_i` before any edge is processed. This applies even when `edge_cnt_i` is 0.
- R3: A pass reads edges at addresses 0 up to `edge_cnt_i`-1, in increasing order and exactly once each. Each read is a one-cycle `edge_rd_o` strobe. The edge data is taken in the cycle after the strobe.
- R4: The root of a vertex is reached by following labels until a vertex whose label equals its own index.
- R5: In threshold mode, two components fuse only if their roots differ and the weight is less than or equal to the threshold of both roots.
- R6: On a fuse, the root with the smaller rank gets the other root as its label. On equal ranks, the neighbour-side root is placed under the source-side root, and the source-side root's rank increases by 1.
- R7: The surviving root's size becomes the sum of the two sizes.
- R8: In threshold mode, the surviving root's threshold becomes weight + floor(`k_i` / merged size). In min-size mode, thresholds are left unchanged.
- R9: A start with `mode_i`=1 (min-size mode) keeps all attributes. It fuses two distinct components when either size is below `min_size_i`.
- R10: An edge whose endpoints already share a root changes no attribute.
- R11: `busy_o` rises in the cycle after an accepted start and stays high until the pass ends. The pass ends with a one-cycle `done_o` pulse, in the same cycle that `busy_o` falls.
- R12: A start pulse while `busy_o` is high is ignored. The running pass finishes with its original mode and edge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a pass when idle |
| mode_i | input | 1 | 0 threshold pass, 1 min-size pass |
| edge_cnt_i | input | E_W | Number of edges in the list |
| thr_init_i | input | TH_W | Global starting threshold |
| k_i | input | K_W | Threshold scale constant k |
| min_size_i | input | SZ_W | Minimum component size |
| edge_rd_o | output | 1 | Edge store read strobe |
| edge_addr_o | output | EA_W | Edge store address |
| edge_src_i | input | V_W | Source vertex, one cycle after strobe |
| edge_dst_i | input | V_W | Neighbour vertex, one cycle after strobe |
| edge_wt_i | input | W_W | Edge weight, one cycle after strobe |
| qry_vtx_i | input | V_W | Vertex to inspect |
| qry_label_o | output | V_W | Label of queried vertex |
| qry_rank_o | output | RK_W | Rank of queried vertex |
| qry_size_o | output | SZ_W | Size of queried vertex |
| qry_thr_o | output | TH_W | Threshold of queried vertex |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
A wrong root, a wrong rank comparison or a missed threshold test usually leaves no trace on the edge interface. It shows up only in the final forest, read through the query port after `done_o`. A bad decision can also surface indirectly, since it changes later fuse decisions within the same pass. A wrong sum or quotient is visible at the query port right after the pass, on the surviving root's size or threshold. Sequencing faults, such as a skipped or repeated address, an extra `done_o` cycle or a restart while busy, appear on the edge strobe and the status pins in the cycle they occur.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_FETCH, ST_LOAD, ST_FIND, ST_DECIDE, ST_JOIN, ST_NEXT
  } seg_state_e;

  typedef enum logic {
    MODE_THRESH = 1'b0,
    MODE_SIZE   = 1'b1
  } seg_mode_e;
endpackage

// File: rtl/seg_find_unit.sv
module seg_find_unit #(
  parameter int V_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [V_W-1:0] vtx_i,
  output logic [V_W-1:0] lbl_addr_o,
  input  logic [V_W-1:0] lbl_data_i,
  output logic [V_W-1:0] root_o,
  output logic           found_o
);
  logic [V_W-1:0] cur_q;
  logic           walk_q;
  logic           found_q;

  // one parent hop per cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      walk_q  <= 1'b0;
      found_q <= 1'b0;
    end else if (start_i) begin
      cur_q   <= vtx_i;
      walk_q  <= 1'b1;
      found_q <= 1'b0;
    end else if (walk_q) begin
      if (lbl_data_i == cur_q) begin
        walk_q  <= 1'b0;
        found_q <= 1'b1;
      end else begin
        cur_q <= lbl_data_i;
      end
    end
  end

  assign lbl_addr_o = cur_q;
  assign root_o     = cur_q;
  assign found_o    = found_q;
endmodule

// File: rtl/seg_divider.sv
module seg_divider #(
  parameter int N_W = 8,
  parameter int D_W = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N_W-1:0] num_i,
  input  logic [D_W-1:0] den_i,
  output logic [N_W-1:0] quo_o,
  output logic           done_o
);
  localparam int CNT_W = $clog2(N_W + 1);

  logic [D_W-1:0]   rem_q;
  logic [D_W-1:0]   den_q;
  logic [N_W-1:0]   num_q;
  logic [N_W-1:0]   quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             done_q;
  logic [D_W:0]     trial;
  logic             fits;

  assign trial = {rem_q, num_q[N_W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      num_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        den_q <= den_i;
        num_q <= num_i;
        quo_q <= '0;
        cnt_q <= CNT_W'(N_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? D_W'(trial - {1'b0, den_q}) : trial[D_W-1:0];
        num_q <= num_q << 1;
        quo_q <= {quo_q[N_W-2:0], fits};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o  = quo_q;
  assign done_o = done_q;
endmodule

// File: rtl/seg_join_unit.sv
module seg_join_unit #(
  parameter int V_W  = 4,
  parameter int RK_W = 3,
  parameter int SZ_W = 5,
  parameter int W_W  = 8,
  parameter int K_W  = 8,
  parameter int TH_W = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            use_thr_i,
  input  logic [V_W-1:0]  root_a_i,
  input  logic [V_W-1:0]  root_b_i,
  input  logic [RK_W-1:0] rank_a_i,
  input  logic [RK_W-1:0] rank_b_i,
  input  logic [SZ_W-1:0] size_a_i,
  input  logic [SZ_W-1:0] size_b_i,
  input  logic [W_W-1:0]  wt_i,
  input  logic [K_W-1:0]  k_i,
  output logic            done_o,
  output logic [V_W-1:0]  parent_o,
  output logic [V_W-1:0]  child_o,
  output logic [RK_W-1:0] rank_o,
  output logic [SZ_W-1:0] size_o,
  output logic [TH_W-1:0] thr_o,
  output logic            thr_wr_o
);
  logic [SZ_W-1:0] size_sum;
  logic [K_W-1:0]  quo;
  logic            div_done;
  logic            div_start;
  logic [W_W-1:0]  wt_q;
  logic            use_q;
  logic            done_q;

  assign size_sum  = size_a_i + size_b_i;
  assign div_start = start_i && use_thr_i;

  seg_divider #(.N_W(K_W), .D_W(SZ_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (k_i),
    .den_i  (size_sum),
    .quo_o  (quo),
    .done_o (div_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      parent_o <= '0;
      child_o  <= '0;
      rank_o   <= '0;
      size_o   <= '0;
      wt_q     <= '0;
      use_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= div_done;
      if (start_i) begin
        size_o <= size_sum;
        wt_q   <= wt_i;
        use_q  <= use_thr_i;
        if (!use_thr_i) done_q <= 1'b1;
        if (rank_a_i < rank_b_i) begin
          parent_o <= root_b_i;
          child_o  <= root_a_i;
          rank_o   <= rank_b_i;
        end else begin
          parent_o <= root_a_i;
          child_o  <= root_b_i;
          rank_o   <= (rank_a_i == rank_b_i) ? rank_a_i + RK_W'(1) : rank_a_i;
        end
      end
    end
  end

  assign thr_o    = TH_W'(wt_q) + TH_W'(quo);
  assign thr_wr_o = use_q;
  assign done_o   = done_q;
endmodule

// File: rtl/seg_merge_engine.sv
module seg_merge_engine #(
  parameter int NUM_V = 16,
  parameter int NUM_E = 32,
  parameter int W_W   = 8,
  parameter int K_W   = 8,
  parameter int V_W   = $clog2(NUM_V),
  parameter int EA_W  = $clog2(NUM_E),
  parameter int E_W   = $clog2(NUM_E + 1),
  parameter int SZ_W  = $clog2(NUM_V + 1),
  parameter int RK_W  = $clog2(V_W + 1),
  parameter int TH_W  = ((W_W > K_W) ? W_W : K_W) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            mode_i,
  input  logic [E_W-1:0]  edge_cnt_i,
  input  logic [TH_W-1:0] thr_init_i,
  input  logic [K_W-1:0]  k_i,
  input  logic [SZ_W-1:0] min_size_i,
  output logic            edge_rd_o,
  output logic [EA_W-1:0] edge_addr_o,
  input  logic [V_W-1:0]  edge_src_i,
  input  logic [V_W-1:0]  edge_dst_i,
  input  logic [W_W-1:0]  edge_wt_i,
  input  logic [V_W-1:0]  qry_vtx_i,
  output logic [V_W-1:0]  qry_label_o,
  output logic [RK_W-1:0] qry_rank_o,
  output logic [SZ_W-1:0] qry_size_o,
  output logic [TH_W-1:0] qry_thr_o,
  output logic            busy_o,
  output logic            done_o
);
  import seg_pkg::*;

  localparam int N_FIND = 2;

  seg_state_e      state_q;
  seg_mode_e       mode_q;
  logic [EA_W-1:0] idx_q;
  logic [E_W-1:0]  ecnt_q;
  logic [TH_W-1:0] thr0_q;
  logic [K_W-1:0]  k_q;
  logic [SZ_W-1:0] min_q;
  logic [W_W-1:0]  wt_q;
  logic            busy_q;
  logic            done_q;

  logic [V_W-1:0]  lbl_q  [NUM_V];
  logic [RK_W-1:0] rank_q [NUM_V];
  logic [SZ_W-1:0] size_q [NUM_V];
  logic [TH_W-1:0] thr_q  [NUM_V];

  logic            find_start;
  logic [V_W-1:0]  find_vtx   [N_FIND];
  logic [V_W-1:0]  find_addr  [N_FIND];
  logic [V_W-1:0]  find_data  [N_FIND];
  logic [V_W-1:0]  find_root  [N_FIND];
  logic            find_ok    [N_FIND];

  logic [V_W-1:0]  ra, rb;
  logic            thr_pass, size_pass, do_merge, last_edge;
  logic            init_en, join_start, join_done, wr_en;
  logic [V_W-1:0]  j_parent, j_child;
  logic [RK_W-1:0] j_rank;
  logic [SZ_W-1:0] j_size;
  logic [TH_W-1:0] j_thr;
  logic            j_thr_wr;

  assign find_start = (state_q == ST_LOAD);
  assign find_vtx[0] = edge_src_i;
  assign find_vtx[1] = edge_dst_i;

  for (genvar g = 0; g < N_FIND; g++) begin : g_find
    seg_find_unit #(.V_W(V_W)) u_find (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (find_start),
      .vtx_i     (find_vtx[g]),
      .lbl_addr_o(find_addr[g]),
      .lbl_data_i(find_data[g]),
      .root_o    (find_root[g]),
      .found_o   (find_ok[g])
    );
    assign find_data[g] = lbl_q[find_addr[g]];
  end

  assign ra        = find_root[0];
  assign rb        = find_root[1];
  assign thr_pass  = (TH_W'(wt_q) <= thr_q[ra]) && (TH_W'(wt_q) <= thr_q[rb]);
  assign size_pass = (size_q[ra] < min_q) || (size_q[rb] < min_q);
  assign do_merge  = (ra != rb) && ((mode_q == MODE_THRESH) ? thr_pass : size_pass);
  assign last_edge = (E_W'(idx_q) + E_W'(1)) == ecnt_q;

  assign init_en    = (state_q == ST_INIT) && (mode_q == MODE_THRESH);
  assign join_start = (state_q == ST_DECIDE) && do_merge;
  assign wr_en      = (state_q == ST_JOIN) && join_done;

  seg_join_unit #(
    .V_W(V_W), .RK_W(RK_W), .SZ_W(SZ_W), .W_W(W_W), .K_W(K_W), .TH_W(TH_W)
  ) u_join (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (join_start),
    .use_thr_i(mode_q == MODE_THRESH),
    .root_a_i (ra),
    .root_b_i (rb),
    .rank_a_i (rank_q[ra]),
    .rank_b_i (rank_q[rb]),
    .size_a_i (size_q[ra]),
    .size_b_i (size_q[rb]),
    .wt_i     (wt_q),
    .k_i      (k_q),
    .done_o   (join_done),
    .parent_o (j_parent),
    .child_o  (j_child),
    .rank_o   (j_rank),
    .size_o   (j_size),
    .thr_o    (j_thr),
    .thr_wr_o (j_thr_wr)
  );

  // control
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_THRESH;
      idx_q   <= '0;
      ecnt_q  <= '0;
      thr0_q  <= '0;
      k_q     <= '0;
      min_q   <= '0;
      wt_q    <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q  <= seg_mode_e'(mode_i);
          ecnt_q  <= edge_cnt_i;
          thr0_q  <= thr_init_i;
          k_q     <= k_i;
          min_q   <= min_size_i;
          idx_q   <= '0;
          busy_q  <= 1'b1;
          state_q <= ST_INIT;
        end
        ST_INIT: begin
          if (ecnt_q == '0) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD: begin
          wt_q    <= edge_wt_i;
          state_q <= ST_FIND;
        end
        ST_FIND:   if (find_ok[0] && find_ok[1]) state_q <= ST_DECIDE;
        ST_DECIDE: state_q <= do_merge ? ST_JOIN : ST_NEXT;
        ST_JOIN:   if (join_done) state_q <= ST_NEXT;
        ST_NEXT: begin
          if (last_edge) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q + EA_W'(1);
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // attribute arrays
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_V; i++) begin
        lbl_q[i]  <= V_W'(i);
        rank_q[i] <= '0;
        size_q[i] <= SZ_W'(1);
        thr_q[i]  <= '0;
      end
    end else if (init_en) begin
      for (int i = 0; i < NUM_V; i++) begin
        lbl_q[i]  <= V_W'(i);
        rank_q[i] <= '0;
        size_q[i] <= SZ_W'(1);
        thr_q[i]  <= thr0_q;
      end
    end else if (wr_en) begin
      lbl_q[j_child]   <= j_parent;
      rank_q[j_parent] <= j_rank;
      size_q[j_parent] <= j_size;
      if (j_thr_wr) thr_q[j_parent] <= j_thr;
    end
  end

  assign edge_rd_o   = (state_q == ST_FETCH);
  assign edge_addr_o = idx_q;
  assign qry_label_o = lbl_q[qry_vtx_i];
  assign qry_rank_o  = rank_q[qry_vtx_i];
  assign qry_size_o  = size_q[qry_vtx_i];
  assign qry_thr_o   = thr_q[qry_vtx_i];
  assign busy_o      = busy_q;
  assign done_o      = done_q;
endmodule

// File: rtl/seg_merge_chk.sv
module seg_merge_chk #(
  parameter int EA_W = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            done_o,
  input logic            edge_rd_o,
  input logic [EA_W-1:0] edge_addr_o
);
  logic            seen_q;
  logic [EA_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (!busy_o) begin
      seen_q <= 1'b0;
    end else if (edge_rd_o) begin
      seen_q <= 1'b1;
      last_q <= edge_addr_o;
    end
  end

  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_done_drops_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r11_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));
  a_r3_read_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_rd_o |-> busy_o);
  a_r3_first_addr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_rd_o && !seen_q) |-> (edge_addr_o == '0));
  a_r3_addr_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_rd_o && seen_q) |-> (edge_addr_o == last_q + EA_W'(1)));
endmodule

bind seg_merge_engine seg_merge_chk #(.EA_W(EA_W)) u_seg_merge_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .edge_rd_o  (edge_rd_o),
  .edge_addr_o(edge_addr_o)
);

// File: tb/seg_merge_engine_bench.sv
module seg_merge_engine_bench;
  localparam int NUM_V = 16;
  localparam int NUM_E = 32;
  localparam int W_W   = 8;
  localparam int K_W   = 8;
  localparam int V_W   = 4;
  localparam int EA_W  = 5;
  localparam int E_W   = 6;
  localparam int SZ_W  = 5;
  localparam int RK_W  = 3;
  localparam int TH_W  = 9;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic            mode_i = 1'b0;
  logic [E_W-1:0]  edge_cnt_i = '0;
  logic [TH_W-1:0] thr_init_i = '0;
  logic [K_W-1:0]  k_i = '0;
  logic [SZ_W-1:0] min_size_i = '0;
  logic            edge_rd_o;
  logic [EA_W-1:0] edge_addr_o;
  logic [V_W-1:0]  edge_src_i, edge_dst_i;
  logic [W_W-1:0]  edge_wt_i;
  logic [V_W-1:0]  qry_vtx_i = '0;
  logic [V_W-1:0]  qry_label_o;
  logic [RK_W-1:0] qry_rank_o;
  logic [SZ_W-1:0] qry_size_o;
  logic [TH_W-1:0] qry_thr_o;
  logic            busy_o, done_o;

  always #5 clk_i = ~clk_i;

  seg_merge_engine u_seg_merge_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .edge_cnt_i(edge_cnt_i), .thr_init_i(thr_init_i), .k_i(k_i),
    .min_size_i(min_size_i), .edge_rd_o(edge_rd_o), .edge_addr_o(edge_addr_o),
    .edge_src_i(edge_src_i), .edge_dst_i(edge_dst_i), .edge_wt_i(edge_wt_i),
    .qry_vtx_i(qry_vtx_i), .qry_label_o(qry_label_o), .qry_rank_o(qry_rank_o),
    .qry_size_o(qry_size_o), .qry_thr_o(qry_thr_o), .busy_o(busy_o), .done_o(done_o)
  );

  // edge store, one-cycle read latency
  int e_src [NUM_E];
  int e_dst [NUM_E];
  int e_wt  [NUM_E];
  always_ff @(posedge clk_i) begin
    if (edge_rd_o) begin
      edge_src_i <= V_W'(e_src[edge_addr_o]);
      edge_dst_i <= V_W'(e_dst[edge_addr_o]);
      edge_wt_i  <= W_W'(e_wt[edge_addr_o]);
    end
  end

  // reference model
  int m_lbl [NUM_V];
  int m_rank[NUM_V];
  int m_size[NUM_V];
  int m_thr [NUM_V];
  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int m_find(int v);
    int r = v;
    while (m_lbl[r] != r) r = m_lbl[r];
    return r;
  endfunction

  task automatic m_reset_all(int thr);
    for (int v = 0; v < NUM_V; v++) begin
      m_lbl[v] = v; m_rank[v] = 0; m_size[v] = 1; m_thr[v] = thr;
    end
  endtask

  task automatic m_pass(int mode, int cnt, int thr0, int k, int minsz);
    if (mode == 0) m_reset_all(thr0);
    for (int e = 0; e < cnt; e++) begin
      int a, b, p, c, sum;
      bit go;
      a = m_find(e_src[e]);
      b = m_find(e_dst[e]);
      if (mode == 0) go = (a != b) && e_wt[e] <= m_thr[a] && e_wt[e] <= m_thr[b];
      else           go = (a != b) && (m_size[a] < minsz || m_size[b] < minsz);
      if (go) begin
        sum = m_size[a] + m_size[b];
        if (m_rank[a] < m_rank[b]) begin p = b; c = a; end
        else begin
          p = a; c = b;
          if (m_rank[a] == m_rank[b]) m_rank[a]++;
        end
        m_lbl[c] = p;
        m_size[p] = sum;
        if (mode == 0) m_thr[p] = e_wt[e] + k / sum;
      end
    end
  endtask

  task automatic compare_all(string tag);
    for (int v = 0; v < NUM_V; v++) begin
      qry_vtx_i = V_W'(v);
      #1;
      chk(tag,  int'(qry_label_o), m_lbl[v],  $sformatf("label[%0d]", v));
      chk("R6", int'(qry_rank_o),  m_rank[v], $sformatf("rank[%0d]", v));
      chk("R7", int'(qry_size_o),  m_size[v], $sformatf("size[%0d]", v));
      chk("R8", int'(qry_thr_o),   m_thr[v],  $sformatf("thr[%0d]", v));
    end
  endtask

  task automatic set_edge(int i, int s, int d, int w);
    e_src[i] = s; e_dst[i] = d; e_wt[i] = w;
  endtask

  task automatic run_pass(string tag, int mode, int cnt, int thr0, int k, int minsz, bit inject);
    int rd_n = 0;
    int cyc = 0;
    bit fin = 0;
    @(negedge clk_i);
    start_i = 1'b1; mode_i = mode[0]; edge_cnt_i = E_W'(cnt);
    thr_init_i = TH_W'(thr0); k_i = K_W'(k); min_size_i = SZ_W'(minsz);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R11", int'(busy_o), 1, "busy after start");
    while (!fin && cyc < 4000) begin
      if (edge_rd_o) begin
        chk("R3", int'(edge_addr_o), rd_n, "edge address");
        rd_n++;
      end
      if (done_o) fin = 1;
      else begin
        // R12: a second start while busy
        if (inject && cyc == 4) begin
          start_i = 1'b1; mode_i = 1'b1; edge_cnt_i = E_W'(1);
        end else start_i = 1'b0;
        @(negedge clk_i);
        cyc++;
      end
    end
    start_i = 1'b0;
    chk(tag, int'(fin), 1, "watchdog, pass completion");
    chk("R3", rd_n, cnt, "edge read count");
    chk("R11", int'(busy_o), 0, "busy with done");
    @(negedge clk_i);
    chk("R11", int'(done_o), 0, "done width");
    chk("R11", int'(busy_o), 0, "idle after done");
    m_pass(mode, cnt, thr0, k, minsz);
    compare_all(tag);
  endtask

  initial begin
    m_reset_all(0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", int'(busy_o), 0, "busy at reset");
    chk("R1", int'(done_o), 0, "done at reset");
    compare_all("R1");

    // R4, R5: threshold pass with chains, rejects and a repeated pair
    set_edge(0, 0, 1, 2);   set_edge(1, 2, 3, 3);   set_edge(2, 1, 2, 5);
    set_edge(3, 4, 5, 6);   set_edge(4, 0, 3, 7);   set_edge(5, 5, 6, 10);
    set_edge(6, 6, 7, 25);  set_edge(7, 8, 9, 30);  set_edge(8, 3, 4, 40);
    set_edge(9, 10, 11, 4); set_edge(10, 11, 12, 4); set_edge(11, 12, 13, 50);
    set_edge(12, 14, 15, 1); set_edge(13, 13, 14, 60);
    run_pass("R5", 0, 14, 20, 60, 0, 1'b0);

    // R9: min-size pass on the previous forest
    set_edge(0, 3, 4, 0);  set_edge(1, 7, 8, 0);  set_edge(2, 9, 10, 0);
    set_edge(3, 12, 13, 0); set_edge(4, 14, 15, 0); set_edge(5, 13, 14, 0);
    set_edge(6, 6, 7, 0);
    run_pass("R9", 1, 7, 0, 0, 3, 1'b0);

    // R10, R6: self edge, repeated root pair, equal ranks, heavy edge rejected
    set_edge(0, 1, 0, 9);  set_edge(1, 3, 2, 9);  set_edge(2, 2, 0, 9);
    set_edge(3, 5, 4, 1);  set_edge(4, 4, 4, 1);  set_edge(5, 4, 5, 1);
    set_edge(6, 7, 6, 200); set_edge(7, 3, 1, 9);
    run_pass("R10", 0, 8, 100, 0, 0, 1'b0);

    // R2: empty list still reinitialises
    run_pass("R2", 0, 0, 7, 5, 0, 1'b0);

    // R12: start during a pass is ignored
    set_edge(0, 8, 9, 3);  set_edge(1, 9, 10, 3); set_edge(2, 10, 11, 3);
    set_edge(3, 11, 12, 3); set_edge(4, 12, 13, 3);
    run_pass("R12", 0, 5, 50, 200, 0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule